// File: doc/BRIEF.md
# Bidirectional motor-speed telemetry decoder

This block turns the reply an electronic speed controller sends back on a shared motor line into a speed figure. It takes a stream of capture timestamps, one per line edge, from a capture timer. The first timestamp of a reply is dropped and the second is kept as the time reference. Each later edge interval is rounded to a whole number of bit times, and that many copies of the current line level are appended to a 21-bit stream. The level starts at one and flips after every interval. A timestamp of zero closes the reply.

The closed stream is zero-padded on the right to 21 bits and transition-decoded (each bit XOR its upper neighbour). The low 20 bits are then split into four 5-bit group codes, and each code is mapped back to a 4-bit nibble. The resulting 16-bit word holds a 3-bit exponent, a 9-bit mantissa and a 4-bit check nibble. When the check nibble is good, the electrical period in microseconds is the mantissa shifted left by the exponent. A bit-serial divider then forms the speed in electrical revolutions per minute as 60,000,000 divided by the period.

Every outcome is visible at the ports. A good reply gives a one-cycle result pulse with the period and the speed. A rejected reply gives a one-cycle error pulse with a cause code. Four counters record good replies, bad group codes, check failures and empty replies.

Top module: `erpm_decoder`

## Requirements
- R1: Within a reply, the first timestamp is discarded and the second sets the reference time. A timestamp of 0 ends the reply at any point, and the next nonzero timestamp starts a new reply.
- R2: Each later timestamp adds floor((delta + 5) / 20) bits, where delta is the difference from the previous timestamp modulo 2^16. The first run added in a reply is ones, and the level flips after every interval, including one that adds no bits.
- R3: A reply that ends with fewer than 21 bits is shifted left and zero-filled to 21 bits before decoding. If more than 21 bits arrive, only the latest 21 are kept.
- R4: The decoded word is formed as g = s ^ (s >> 1) over the 21-bit stream s. Bits g[4:0] give nibble 0 (bits 3:0 of the word), and each higher 5-bit group gives the next nibble. The codes 0x19,0x1B,0x12,0x13,0x1D,0x15,0x16,0x17,0x1A,0x09,0x0A,0x0B,0x1E,0x0D,0x0E,0x0F stand for nibbles 0 to 15 in that order. Any other code rejects the reply with cause 2.
- R5: In the 16-bit word, bits 15:13 are the exponent and bits 12:4 the mantissa. The reported period is mantissa << exponent.
- R6: With p = word[15:4], the check nibble word[3:0] must equal ~(p ^ p>>4 ^ p>>8) & 0xF. Otherwise the reply is rejected with cause 3.
- R7: A reply that adds no bits is rejected with cause 1. When several faults apply, empty wins over a bad code, and a bad code wins over a check failure.
- R8: A good reply whose period is 65408 or 0 reports speed 0, with the result pulse on the second clock edge after the closing timestamp is sampled.
- R9: Any other good reply reports floor(60,000,000 / period). Exactly one result pulse is raised, and only after the multi-cycle divider finishes.
- R10: A rejected reply gives exactly one err_valid pulse, never together with res_valid. At that pulse err_cause holds the nonzero cause, and res_erpm and res_period read 0.
- R11: cnt_good, cnt_bad_code, cnt_bad_check and cnt_empty start at 0 and each rises by exactly one per reply of its kind.
- R12: After reset, both pulses are low and all data outputs and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_valid | input | 1 | A capture timestamp is present this cycle |
| edge_time | input | TS_W (16) | Capture timestamp in ticks; 0 closes the reply |
| res_valid | output | 1 | One-cycle pulse: a good reply has been decoded |
| res_period | output | 16 | Electrical period in microseconds |
| res_erpm | output | ERPM_W (26) | Speed in electrical revolutions per minute |
| err_valid | output | 1 | One-cycle pulse: the reply was rejected |
| err_cause | output | 2 | 1 empty, 2 bad group code, 3 check failure |
| cnt_good | output | CNT_W (16) | Good replies |
| cnt_bad_code | output | CNT_W (16) | Replies with an unknown group code |
| cnt_bad_check | output | CNT_W (16) | Replies failing the check nibble |
| cnt_empty | output | CNT_W (16) | Replies with no bits |

## Verification
The bench encodes random exponent and mantissa pairs into edge timestamps. It uses interval jitter at both ends of the rounding window (-5 and +14 ticks) and sometimes drops the trailing zero run. A rounding error would add or lose a bit and corrupt the codes, and a missing pad would slide every group by one position. Directed replies cover the stopped value 65408, a zero mantissa, the largest speed, a wrong check nibble, an illegal code, and empty replies with and without edges. A design with the wrong error priority would count the wrong kind. A design that pulsed the result before the divider finished would report a partial quotient.

// File: rtl/erpm_pkg.sv
package erpm_pkg;

  localparam int FRAME_BITS = 21;
  localparam int WORD_BITS  = 16;
  localparam int SYM_BITS   = 5;
  localparam int NUM_SYMS   = 4;
  localparam logic [15:0] STOPPED_PERIOD = 16'd65408;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EMPTY = 2'd1,
    CAUSE_CODE  = 2'd2,
    CAUSE_CHECK = 2'd3
  } cause_e;

  // Returns {illegal, nibble} for one 5-bit group code.
  function automatic logic [4:0] code_to_nibble(input logic [4:0] code);
    logic [4:0] r;
    case (code)
      5'h19: r = 5'h00;
      5'h1B: r = 5'h01;
      5'h12: r = 5'h02;
      5'h13: r = 5'h03;
      5'h1D: r = 5'h04;
      5'h15: r = 5'h05;
      5'h16: r = 5'h06;
      5'h17: r = 5'h07;
      5'h1A: r = 5'h08;
      5'h09: r = 5'h09;
      5'h0A: r = 5'h0A;
      5'h0B: r = 5'h0B;
      5'h1E: r = 5'h0C;
      5'h0D: r = 5'h0D;
      5'h0E: r = 5'h0E;
      5'h0F: r = 5'h0F;
      default: r = 5'h10;
    endcase
    return r;
  endfunction

  // Check nibble expected for the 12-bit payload.
  function automatic logic [3:0] check_nibble(input logic [11:0] p);
    logic [11:0] x;
    x = p ^ (p >> 4) ^ (p >> 8);
    return ~x[3:0];
  endfunction

  // Exponent-mantissa period.
  function automatic logic [15:0] word_period(input logic [15:0] w);
    return 16'(w[12:4]) << w[15:13];
  endfunction

endpackage

// File: rtl/erpm_edge_collector.sv
module erpm_edge_collector
  import erpm_pkg::*;
#(
  parameter int TS_W         = 16,
  parameter int TICK_PER_BIT = 20,
  parameter int TICK_ROUND   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  edge_valid,
  input  logic [TS_W-1:0]       edge_time,
  output logic                  fr_done,
  output logic [FRAME_BITS-1:0] fr_bits,
  output logic [4:0]            fr_count
);

  localparam int FB = FRAME_BITS;

  typedef enum logic [1:0] {PH_SKIP, PH_REF, PH_RUN} phase_e;

  phase_e              phase_q;
  logic [TS_W-1:0]     prev_q;
  logic                level_q;
  logic [FB-1:0]       bits_q;
  logic [4:0]          count_q;

  // Bits represented by one edge interval, clamped to the frame length.
  function automatic logic [4:0] run_bits(input logic [TS_W-1:0] delta);
    logic [TS_W:0] s;
    logic [TS_W:0] q;
    s = {1'b0, delta} + (TS_W+1)'(TICK_ROUND);
    q = s / (TS_W+1)'(TICK_PER_BIT);
    if (q > (TS_W+1)'(FB)) return 5'(FB);
    return q[4:0];
  endfunction

  logic              close_w;
  logic              interval_w;
  logic [4:0]        run_w;
  logic [2*FB-1:0]   ext_w;
  logic [2*FB-1:0]   fill_w;
  logic [FB-1:0]     bits_next_w;
  logic [5:0]        sum_w;
  logic [4:0]        count_next_w;

  assign close_w    = edge_valid && (edge_time == '0);
  assign interval_w = edge_valid && !close_w && (phase_q == PH_RUN);
  assign run_w      = run_bits(edge_time - prev_q);

  always_comb begin
    ext_w  = {{FB{1'b0}}, bits_q} << run_w;
    fill_w = ({{(2*FB-1){1'b0}}, 1'b1} << run_w) - 1'b1;
    bits_next_w = level_q ? (ext_w[FB-1:0] | fill_w[FB-1:0]) : ext_w[FB-1:0];
    sum_w = {1'b0, count_q} + {1'b0, run_w};
    count_next_w = (sum_w > 6'(FB)) ? 5'(FB) : sum_w[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_SKIP;
      prev_q   <= '0;
      level_q  <= 1'b1;
      bits_q   <= '0;
      count_q  <= '0;
      fr_done  <= 1'b0;
      fr_bits  <= '0;
      fr_count <= '0;
    end else begin
      fr_done <= 1'b0;
      if (close_w) begin
        fr_done  <= 1'b1;
        fr_bits  <= bits_q;
        fr_count <= count_q;
        phase_q  <= PH_SKIP;
        level_q  <= 1'b1;
        bits_q   <= '0;
        count_q  <= '0;
      end else if (edge_valid) begin
        case (phase_q)
          PH_SKIP: phase_q <= PH_REF;
          PH_REF: begin
            prev_q  <= edge_time;
            phase_q <= PH_RUN;
          end
          default: begin
            prev_q  <= edge_time;
            level_q <= ~level_q;
            bits_q  <= bits_next_w;
            count_q <= count_next_w;
          end
        endcase
      end
    end
  end

  // R1: a frame report follows only a closing timestamp
  a_r1_done_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |-> $past(edge_valid && (edge_time == '0)));

  // R2: every interval flips the level used for the next run
  a_r2_level_flips: assert property (@(posedge clk) disable iff (!rst_n)
    interval_w |=> (level_q != $past(level_q)));

  // R3: the bit count never runs past the frame length
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |-> (fr_count <= 5'(FB)));

endmodule

// File: rtl/erpm_frame_check.sv
module erpm_frame_check
  import erpm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fr_done,
  input  logic [FRAME_BITS-1:0] fr_bits,
  input  logic [4:0]            fr_count,
  output cause_e                cause,
  output logic [15:0]           period,
  output logic                  zero_rate
);

  localparam int FB = FRAME_BITS;

  logic [FB-1:0]       padded_w;
  logic [FB-1:0]       trans_w;
  logic [NUM_SYMS-1:0] illegal_w;
  logic [WORD_BITS-1:0] word_w;
  logic                check_ok_w;

  always_comb begin
    padded_w = fr_bits << (5'(FB) - fr_count);
    trans_w  = padded_w ^ (padded_w >> 1);
  end

  for (genvar s = 0; s < NUM_SYMS; s++) begin : g_sym
    logic [4:0] dec;
    assign dec = code_to_nibble(trans_w[s*SYM_BITS +: SYM_BITS]);
    assign illegal_w[s]     = dec[4];
    assign word_w[s*4 +: 4] = dec[3:0];
  end

  assign check_ok_w = (check_nibble(word_w[15:4]) == word_w[3:0]);
  assign period     = word_period(word_w);
  assign zero_rate  = (period == STOPPED_PERIOD) || (period == '0);

  always_comb begin
    if (fr_count == '0)    cause = CAUSE_EMPTY;
    else if (|illegal_w)   cause = CAUSE_CODE;
    else if (!check_ok_w)  cause = CAUSE_CHECK;
    else                   cause = CAUSE_NONE;
  end

  // R7: a frame with no bits is always reported empty
  a_r7_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && fr_count == '0) |-> (cause == CAUSE_EMPTY));

  // R4: an accepted frame used only legal codes
  a_r4_legal_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && cause == CAUSE_NONE) |-> (illegal_w == '0));

endmodule

// File: rtl/erpm_seq_div.sv
module erpm_seq_div #(
  parameter int NUM = 60_000_000,
  parameter int DW  = 16,
  parameter int QW  = $clog2(NUM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quot
);

  localparam int CW = $clog2(QW + 1);

  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [QW-1:0] acc_q;
  logic [CW-1:0] step_q;
  logic [DW:0]   trial_w;
  logic          take_w;

  assign trial_w = {rem_q, acc_q[QW-1]};
  assign take_w  = trial_w >= {1'b0, den_q};
  assign quot    = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      den_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      step_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        den_q  <= den;
        rem_q  <= '0;
        acc_q  <= QW'(NUM);
        step_q <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        rem_q  <= take_w ? DW'(trial_w - {1'b0, den_q}) : trial_w[DW-1:0];
        acc_q  <= {acc_q[QW-2:0], take_w};
        step_q <= step_q + 1'b1;
        if (step_q == CW'(QW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9: a start from idle makes the divider busy
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9: completion comes only at the end of a busy run
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

endmodule

// File: rtl/erpm_decoder.sv
module erpm_decoder
  import erpm_pkg::*;
#(
  parameter int TS_W         = 16,
  parameter int CNT_W        = 16,
  parameter int TICK_PER_BIT = 20,
  parameter int TICK_ROUND   = 5,
  parameter int ERPM_NUM     = 60_000_000,
  parameter int ERPM_W       = $clog2(ERPM_NUM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_valid,
  input  logic [TS_W-1:0]   edge_time,
  output logic              res_valid,
  output logic [15:0]       res_period,
  output logic [ERPM_W-1:0] res_erpm,
  output logic              err_valid,
  output logic [1:0]        err_cause,
  output logic [CNT_W-1:0]  cnt_good,
  output logic [CNT_W-1:0]  cnt_bad_code,
  output logic [CNT_W-1:0]  cnt_bad_check,
  output logic [CNT_W-1:0]  cnt_empty
);

  logic                  fr_done;
  logic [FRAME_BITS-1:0] fr_bits;
  logic [4:0]            fr_count;
  cause_e                cause;
  logic [15:0]           period;
  logic                  zero_rate;
  logic                  div_start;
  logic                  div_busy;
  logic                  div_done;
  logic [ERPM_W-1:0]     div_quot;
  logic [15:0]           held_period_q;

  erpm_edge_collector #(
    .TS_W(TS_W), .TICK_PER_BIT(TICK_PER_BIT), .TICK_ROUND(TICK_ROUND)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .edge_valid(edge_valid), .edge_time(edge_time),
    .fr_done(fr_done), .fr_bits(fr_bits), .fr_count(fr_count)
  );

  erpm_frame_check u_check (
    .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_bits(fr_bits),
    .fr_count(fr_count), .cause(cause), .period(period), .zero_rate(zero_rate)
  );

  assign div_start = fr_done && (cause == CAUSE_NONE) && !zero_rate;

  erpm_seq_div #(.NUM(ERPM_NUM), .DW(16), .QW(ERPM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .den(period),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_period    <= '0;
      res_erpm      <= '0;
      err_valid     <= 1'b0;
      err_cause     <= '0;
      cnt_good      <= '0;
      cnt_bad_code  <= '0;
      cnt_bad_check <= '0;
      cnt_empty     <= '0;
      held_period_q <= '0;
    end else begin
      res_valid <= 1'b0;
      err_valid <= 1'b0;
      if (div_start && !div_busy) held_period_q <= period;
      if (fr_done && cause != CAUSE_NONE) begin
        err_valid  <= 1'b1;
        err_cause  <= cause;
        res_erpm   <= '0;
        res_period <= '0;
        case (cause)
          CAUSE_EMPTY: cnt_empty     <= cnt_empty + 1'b1;
          CAUSE_CODE:  cnt_bad_code  <= cnt_bad_code + 1'b1;
          default:     cnt_bad_check <= cnt_bad_check + 1'b1;
        endcase
      end else if (fr_done && zero_rate) begin
        res_valid  <= 1'b1;
        res_period <= period;
        res_erpm   <= '0;
        err_cause  <= CAUSE_NONE;
        cnt_good   <= cnt_good + 1'b1;
      end else if (div_done) begin
        res_valid  <= 1'b1;
        res_period <= held_period_q;
        res_erpm   <= div_quot;
        err_cause  <= CAUSE_NONE;
        cnt_good   <= cnt_good + 1'b1;
      end
    end
  end

  // R10: the two pulses never coincide
  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && err_valid));

  // R10: a rejection carries a cause and clears the speed
  a_r10_err_fields: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_cause != 2'd0 && res_erpm == '0 && res_period == '0));

  // R11: a check failure advances its own counter by one
  a_r11_check_count: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_cause == 2'd3) |-> (cnt_bad_check == $past(cnt_bad_check) + 1'b1));

  // R11: a result pulse advances the good counter by one
  a_r11_good_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cnt_good == $past(cnt_good) + 1'b1));

  // R9: a nonzero speed always comes with a nonzero period
  a_r9_speed_has_period: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_erpm != '0) |-> (res_period != '0));

endmodule

// File: tb/erpm_decoder_test.sv
module erpm_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        edge_valid = 1'b0;
  logic [15:0] edge_time = '0;
  logic        res_valid;
  logic [15:0] res_period;
  logic [25:0] res_erpm;
  logic        err_valid;
  logic [1:0]  err_cause;
  logic [15:0] cnt_good, cnt_bad_code, cnt_bad_check, cnt_empty;

  int checks = 0;
  int failures = 0;
  int e_good = 0, e_code = 0, e_check = 0, e_empty = 0;
  int n_res = 0, n_err = 0;
  int g_period = 0, g_erpm = 0, g_cause = 0;

  always #4 clk = ~clk;

  erpm_decoder uut (
    .clk(clk), .rst_n(rst_n), .edge_valid(edge_valid), .edge_time(edge_time),
    .res_valid(res_valid), .res_period(res_period), .res_erpm(res_erpm),
    .err_valid(err_valid), .err_cause(err_cause), .cnt_good(cnt_good),
    .cnt_bad_code(cnt_bad_code), .cnt_bad_check(cnt_bad_check), .cnt_empty(cnt_empty)
  );

  always @(negedge clk) begin
    if (res_valid) begin n_res++; g_period = res_period; g_erpm = res_erpm; end
    if (err_valid) begin n_err++; g_cause = err_cause; g_erpm = res_erpm; g_period = res_period; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic [4:0] nib_code(input [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'h19; 4'h1: c = 5'h1B; 4'h2: c = 5'h12; 4'h3: c = 5'h13;
      4'h4: c = 5'h1D; 4'h5: c = 5'h15; 4'h6: c = 5'h16; 4'h7: c = 5'h17;
      4'h8: c = 5'h1A; 4'h9: c = 5'h09; 4'hA: c = 5'h0A; 4'hB: c = 5'h0B;
      4'hC: c = 5'h1E; 4'hD: c = 5'h0D; 4'hE: c = 5'h0E; default: c = 5'h0F;
    endcase
    return c;
  endfunction

  function automatic [15:0] mk_word(input [2:0] e, input [8:0] m, input bit bad);
    logic [11:0] p;
    logic [11:0] x;
    logic [3:0]  c;
    p = {e, m};
    x = p ^ {4'b0, p[11:4]} ^ {8'b0, p[11:8]};
    c = ~x[3:0];
    if (bad) c = c ^ 4'h5;
    return {p, c};
  endfunction

  function automatic [19:0] to_codes(input [15:0] w);
    return {nib_code(w[15:12]), nib_code(w[11:8]), nib_code(w[7:4]), nib_code(w[3:0])};
  endfunction

  task automatic send(input [15:0] t);
    @(negedge clk);
    edge_valid = 1'b1;
    edge_time  = t;
    @(negedge clk);
    edge_valid = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  // jmode: 0 random jitter, 1 lowest, 2 highest
  task automatic send_codes(input [19:0] g, input bit drop_tail, input int jmode);
    logic [20:0] v;
    int t, i, len, jit;
    v[20] = 1'b1;
    for (int k = 19; k >= 0; k--) v[k] = g[k] ^ v[k+1];
    t = 1000 + $urandom_range(0, 20000);
    send(16'(t - 37));
    send(16'(t));
    i = 20;
    while (i >= 0) begin
      len = 0;
      for (int k = i; k >= 0 && v[k] == v[i]; k--) len++;
      if (!(drop_tail && (i - len < 0) && v[i] == 1'b0)) begin
        jit = (jmode == 1) ? -5 : (jmode == 2) ? 14 : $urandom_range(0, 19) - 5;
        t = t + 20 * len + jit;
        send(16'(t));
      end
      i = i - len;
    end
    send(16'd0);
  endtask

  task automatic expect_good(input [15:0] w, input string tag);
    int per, er;
    per = int'(w[12:4]) << w[15:13];
    er  = (per == 65408 || per == 0) ? 0 : 60000000 / per;
    repeat (40) @(negedge clk);
    e_good++;
    chk(n_res == 1 && n_err == 0, {tag, " one result pulse"}, n_res, 1);
    chk(g_period == per, {tag, " period"}, g_period, per);
    chk(g_erpm == er, {tag, " erpm"}, g_erpm, er);
  endtask

  task automatic expect_err(input int cause, input string tag);
    repeat (40) @(negedge clk);
    chk(n_err == 1 && n_res == 0, {tag, " one error pulse"}, n_err, 1);
    chk(g_cause == cause, {tag, " cause"}, g_cause, cause);
    chk(g_erpm == 0 && g_period == 0, {tag, " cleared outputs"}, g_erpm, 0);
  endtask

  task automatic good_frame(input [2:0] e, input [8:0] m, input bit drop, input int jm, input string tag);
    logic [15:0] w;
    w = mk_word(e, m, 1'b0);
    n_res = 0; n_err = 0;
    send_codes(to_codes(w), drop, jm);
    expect_good(w, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [19:0] g;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!res_valid && !err_valid, "R12 pulses low", res_valid, 0);
    chk(res_erpm == 0 && res_period == 0 && err_cause == 0, "R12 data zero", res_erpm, 0);
    chk(cnt_good == 0 && cnt_bad_code == 0 && cnt_bad_check == 0 && cnt_empty == 0,
        "R12 counters zero", cnt_good, 0);

    // R5 R8: stopped value
    good_frame(3'd7, 9'd511, 1'b0, 0, "R8 stopped");
    // R8: zero mantissa
    good_frame(3'd3, 9'd0, 1'b0, 0, "R8 zero period");
    // R9: largest speed
    good_frame(3'd0, 9'd1, 1'b0, 0, "R9 max speed");
    // R2: jitter at both ends of the rounding window
    good_frame(3'd2, 9'd300, 1'b0, 1, "R2 low jitter");
    good_frame(3'd5, 9'd77, 1'b0, 2, "R2 high jitter");
    // R3: trailing zeros left out and restored by padding
    good_frame(3'd1, 9'd250, 1'b1, 0, "R3 padded tail");

    // R1 R4 R5 R9: random replies
    for (int r = 0; r < 30; r++) begin
      good_frame(3'($urandom_range(0, 7)), 9'($urandom_range(1, 511)),
                 1'($urandom_range(0, 1)), 0, "R9 random");
    end

    // R6: wrong check nibble
    w = mk_word(3'd4, 9'd123, 1'b1);
    n_res = 0; n_err = 0;
    send_codes(to_codes(w), 1'b0, 0);
    expect_err(3, "R6 bad check");
    e_check++;

    // R4 R7: illegal code with a bad check too -> code wins
    g = to_codes(mk_word(3'd2, 9'd45, 1'b1));
    g[9:5] = 5'h00;
    n_res = 0; n_err = 0;
    send_codes(g, 1'b0, 0);
    expect_err(2, "R4 R7 illegal code priority");
    e_code++;

    // R7: edges without any interval
    n_res = 0; n_err = 0;
    send(16'd500); send(16'd900); send(16'd0);
    expect_err(1, "R7 empty after reference");
    e_empty++;

    // R1 R7: closing timestamp alone
    n_res = 0; n_err = 0;
    send(16'd0);
    expect_err(1, "R1 lone close");
    e_empty++;

    // R1: decoder restarts cleanly after errors
    good_frame(3'd6, 9'd200, 1'b0, 0, "R1 restart");

    // R11 counters
    chk(cnt_good == 16'(e_good), "R11 good count", cnt_good, e_good);
    chk(cnt_bad_code == 16'(e_code), "R11 code count", cnt_bad_code, e_code);
    chk(cnt_bad_check == 16'(e_check), "R11 check count", cnt_bad_check, e_check);
    chk(cnt_empty == 16'(e_empty), "R11 empty count", cnt_empty, e_empty);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule